// File: doc/BRIEF.md
# Three-Wire RF Control Register Master

This block is the master end of a three-wire serial control link to a radio transceiver. The link has a strobe line, which is active low while a transfer runs, a serial clock and a data line. A host asks for a register write (4-bit address, 12-bit value) or a register read (address only) over a valid/ready handshake. A read returns its 12-bit value on a single-cycle done pulse.

The block produces every pin level itself. Each phase of a transfer lasts a whole number of microsecond ticks, and the tick comes from a clock-divider parameter. During a read the block lets go of the data pin and raises a direction line, so the transceiver can drive the return bits onto a separate input. After every transfer a quiet period runs before the next request is taken.

Top module: `rfx_serial_master`

## Requirements
- R1: After reset the strobe is high, the serial clock is low, the data output enable and the direction line are low, the ready output is high and the done output is low.
- R2: A request is taken on a clock edge where valid and ready are both high. Ready is low from the cycle after that edge until the closing quiet period has expired. A request presented while ready is low is not taken and changes no transceiver register.
- R3: A write shifts out a 16-bit frame, MSB first: the 12-bit value in bits 15:4 and the address in bits 3:0. There are exactly 16 serial clock rising edges, the data line is stable while the clock is high, and each clock-high phase lasts T_HIGH ticks (default 2).
- R4: After a write is taken, the strobe stays high for T_WR_LEAD ticks (default 2) and then falls. The first clock rise follows T_WR_GAP + T_SETUP ticks later (defaults 10 and 1). For a read these become T_RD_LEAD (4) and T_RD_GAP + T_SETUP (5 + 1).
- R5: At the last write clock fall the strobe rises. Ready returns T_WR_TAIL + T_QUIET ticks later (defaults 10 and 2000). After a read, ready returns T_RD_TAIL + T_QUIET ticks after the strobe rises.
- R6: A read first shifts out 5 address bits MSB first, the top bit being 0 and the low four being the address. Each bit has a T_SETUP low phase and a T_HIGH high phase.
- R7: After the address the direction line rises and the data output enable falls. One turnaround clock pulse follows, then 12 capture pulses, 13 rising edges in all while the direction line is high. Each capture clock-high phase lasts T_CAP_HIGH ticks (default 6) and is preceded by a T_CAP_LOW low phase (default 2).
- R8: The serial input is sampled at the end of each capture clock-high phase, MSB first. The 12 bits are presented on the read data output with a one-cycle done pulse. A write never pulses done.
- R9: A read closes with the strobe high and the direction line still high for T_RD_TAIL ticks (default 2). The direction line then falls and the pins return to idle levels.
- R10: The direction line and the data output enable are never high together, and the serial clock is high only while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Value to write |
| rd_done | output | 1 | One-cycle pulse, read value valid |
| rd_data | output | DATA_W | Value returned by a read |
| rf_stb | output | 1 | Strobe, low during a transfer |
| rf_sclk | output | 1 | Serial clock |
| rf_sdo | output | 1 | Serial data toward the transceiver |
| rf_sdo_oe | output | 1 | Output enable of the data pin |
| rf_rdir | output | 1 | Read direction line |
| rf_sdi | input | 1 | Serial data from the transceiver |

## Verification
The bench uses a transceiver model that keeps a register file. It decodes write frames into that file and plays values back on reads. Frames with set top and bottom bits expose a reversed or misaligned shift as a wrong round-trip value. The bench times each strobe phase, clock-high width and tail from the pins, so a wrong tick count or a phase swapped between the read and write sequences shows up as a width mismatch. It also counts clock edges under the direction line, which catches a missing turnaround pulse or a sample taken one bit early. A request injected while the block is busy must leave its target register unchanged when that register is read back later.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LEAD,
        S_GAP,
        S_BLO,
        S_BHI,
        S_WTAIL,
        S_TLO,
        S_THI,
        S_CLO,
        S_CHI,
        S_RTAIL,
        S_QUIET
    } rfx_state_e;

    function automatic int unsigned rfx_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfx_tick_div.sv
module rfx_tick_div #(
    parameter int unsigned DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        if (clear || pre_q == LAST) pre_d = '0;
        else                        pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = (pre_q == LAST);
endmodule

// File: rtl/rfx_phase_timer.sv
module rfx_phase_timer #(
    parameter int unsigned TW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] ticks,
    input  logic          tick,
    output logic          expire
);
    logic [TW-1:0] left_d, left_q;

    always_comb begin
        if (load)                         left_d = ticks;
        else if (tick && left_q != '0)    left_d = left_q - 1'b1;
        else                              left_d = left_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign expire = tick && (left_q == TW'(1));
endmodule

// File: rtl/rfx_serial_master.sv
module rfx_serial_master
    import rfx_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned CLK_PER_US = 200,
    parameter int unsigned T_WR_LEAD  = 2,
    parameter int unsigned T_WR_GAP   = 10,
    parameter int unsigned T_WR_TAIL  = 10,
    parameter int unsigned T_RD_LEAD  = 4,
    parameter int unsigned T_RD_GAP   = 5,
    parameter int unsigned T_SETUP    = 1,
    parameter int unsigned T_HIGH     = 2,
    parameter int unsigned T_CAP_LOW  = 2,
    parameter int unsigned T_CAP_HIGH = 6,
    parameter int unsigned T_RD_TAIL  = 2,
    parameter int unsigned T_QUIET    = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rf_stb,
    output logic              rf_sclk,
    output logic              rf_sdo,
    output logic              rf_sdo_oe,
    output logic              rf_rdir,
    input  logic              rf_sdi
);
    localparam int unsigned FRAME_W = DATA_W + ADDR_W;
    localparam int unsigned RA_W    = ADDR_W + 1;
    localparam int unsigned CW      = $clog2(rfx_max(FRAME_W, DATA_W) + 1);
    localparam int unsigned T_MAX   = rfx_max(rfx_max(rfx_max(T_WR_LEAD, T_WR_GAP), rfx_max(T_WR_TAIL, T_RD_LEAD)),
                                      rfx_max(rfx_max(rfx_max(T_RD_GAP, T_SETUP), rfx_max(T_HIGH, T_CAP_LOW)),
                                      rfx_max(rfx_max(T_CAP_HIGH, T_RD_TAIL), T_QUIET)));
    localparam int unsigned TW      = $clog2(T_MAX + 1);

    typedef struct packed {
        rfx_state_e        st;
        logic [FRAME_W-1:0] sreg;
        logic [CW-1:0]     bitn;
        logic [DATA_W-1:0] rsh;
        logic              rdop;
        logic              stb;
        logic              sclk;
        logic              sdo;
        logic              oe;
        logic              rdir;
        logic              ready;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t          s_d, s_q;
    logic           tick, expire, load;
    logic [TW-1:0]  ticks;

    rfx_tick_div #(.DIV(CLK_PER_US)) u_div (
        .clk(clk), .rst_n(rst_n), .clear(load), .tick(tick)
    );

    rfx_phase_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(load), .ticks(ticks), .tick(tick), .expire(expire)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            S_IDLE: if (req_valid) begin
                s_d.st   = S_LEAD;
                s_d.rdop = !req_write;
                if (req_write) begin
                    s_d.sreg = {req_wdata, req_addr};
                    s_d.bitn = CW'(FRAME_W);
                end else begin
                    s_d.sreg = {1'b0, req_addr, {(FRAME_W-RA_W){1'b0}}};
                    s_d.bitn = CW'(RA_W);
                end
            end
            S_LEAD:  if (expire) s_d.st = S_GAP;
            S_GAP:   if (expire) s_d.st = S_BLO;
            S_BLO:   if (expire) s_d.st = S_BHI;
            S_BHI: if (expire) begin
                s_d.sreg = {s_q.sreg[FRAME_W-2:0], 1'b0};
                s_d.bitn = s_q.bitn - 1'b1;
                if (s_q.bitn == CW'(1)) s_d.st = s_q.rdop ? S_TLO : S_WTAIL;
                else                    s_d.st = S_BLO;
            end
            S_WTAIL: if (expire) s_d.st = S_QUIET;
            S_TLO:   if (expire) s_d.st = S_THI;
            S_THI: if (expire) begin
                s_d.st   = S_CLO;
                s_d.bitn = CW'(DATA_W);
            end
            S_CLO:   if (expire) s_d.st = S_CHI;
            S_CHI: if (expire) begin
                s_d.rsh  = {s_q.rsh[DATA_W-2:0], rf_sdi};
                s_d.bitn = s_q.bitn - 1'b1;
                s_d.st   = (s_q.bitn == CW'(1)) ? S_RTAIL : S_CLO;
            end
            S_RTAIL: if (expire) begin
                s_d.st    = S_QUIET;
                s_d.done  = 1'b1;
                s_d.rdata = s_q.rsh;
            end
            S_QUIET: if (expire) s_d.st = S_IDLE;
            default: s_d.st = S_IDLE;
        endcase

        // pin levels follow the state being entered
        s_d.stb   = s_d.st inside {S_IDLE, S_LEAD, S_WTAIL, S_RTAIL, S_QUIET};
        s_d.sclk  = s_d.st inside {S_BHI, S_THI, S_CHI};
        s_d.oe    = s_d.st inside {S_LEAD, S_GAP, S_BLO, S_BHI, S_WTAIL};
        s_d.rdir  = s_d.st inside {S_TLO, S_THI, S_CLO, S_CHI, S_RTAIL};
        s_d.sdo   = (s_d.st inside {S_BLO, S_BHI}) ? s_d.sreg[FRAME_W-1] : 1'b0;
        s_d.ready = (s_d.st == S_IDLE);
    end

    // every phase change restarts the tick divider and loads the phase length
    assign load = (s_d.st != s_q.st);

    always_comb begin
        unique case (s_d.st)
            S_LEAD:  ticks = s_d.rdop ? TW'(T_RD_LEAD) : TW'(T_WR_LEAD);
            S_GAP:   ticks = s_d.rdop ? TW'(T_RD_GAP)  : TW'(T_WR_GAP);
            S_BLO:   ticks = TW'(T_SETUP);
            S_TLO:   ticks = TW'(T_SETUP);
            S_BHI:   ticks = TW'(T_HIGH);
            S_THI:   ticks = TW'(T_HIGH);
            S_WTAIL: ticks = TW'(T_WR_TAIL);
            S_CLO:   ticks = TW'(T_CAP_LOW);
            S_CHI:   ticks = TW'(T_CAP_HIGH);
            S_RTAIL: ticks = TW'(T_RD_TAIL);
            S_QUIET: ticks = TW'(T_QUIET);
            default: ticks = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: S_IDLE, stb: 1'b1, ready: 1'b1, default: '0};
        else        s_q <= s_d;
    end

    assign req_ready = s_q.ready;
    assign rd_done   = s_q.done;
    assign rd_data   = s_q.rdata;
    assign rf_stb    = s_q.stb;
    assign rf_sclk   = s_q.sclk;
    assign rf_sdo    = s_q.sdo;
    assign rf_sdo_oe = s_q.oe;
    assign rf_rdir   = s_q.rdir;
endmodule

// File: rtl/rfx_serial_master_chk.sv
module rfx_serial_master_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rd_done,
    input logic rf_stb,
    input logic rf_sclk,
    input logic rf_sdo,
    input logic rf_sdo_oe,
    input logic rf_rdir
);
    // R2
    hs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_stb |-> !req_ready);

    // R3
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_sclk && $past(rf_sclk)) |-> $stable(rf_sdo));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R10
    dir_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rdir |-> !rf_sdo_oe);

    // R10
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_sclk |-> !rf_stb);
endmodule

bind rfx_serial_master rfx_serial_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rd_done(rd_done), .rf_stb(rf_stb), .rf_sclk(rf_sclk), .rf_sdo(rf_sdo),
    .rf_sdo_oe(rf_sdo_oe), .rf_rdir(rf_rdir)
);

// File: tb/tb_rfx_serial_master.sv
`timescale 1ns/1ps
module tb_rfx_serial_master;
    localparam int DIV = 4;
    localparam int TQ  = 20;
    localparam int WL = 2, WG = 10, WT = 10, RL = 4, RG = 5;
    localparam int SU = 1, HI = 2, CL = 2, CH = 6, RT = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [3:0] req_addr = '0;
    logic [11:0] req_wdata = '0;
    logic req_ready, rd_done, rf_stb, rf_sclk, rf_sdo, rf_sdo_oe, rf_rdir;
    logic [11:0] rd_data;
    logic rf_sdi = 1'b0;

    rfx_serial_master #(
        .CLK_PER_US(DIV), .T_QUIET(TQ), .T_CAP_LOW(CL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_done(rd_done), .rd_data(rd_data), .rf_stb(rf_stb), .rf_sclk(rf_sclk),
        .rf_sdo(rf_sdo), .rf_sdo_oe(rf_sdo_oe), .rf_rdir(rf_rdir), .rf_sdi(rf_sdi)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // scoreboard and transceiver model state
    logic [11:0] exp_q[$];
    logic [11:0] exp_regs [16] = '{default: 12'h0};
    logic [11:0] sregs    [16] = '{default: 12'h0};
    logic [15:0] exp_frame = '0;
    bit cur_rd = 0;
    int acc_cyc = 0;

    // monitor / transceiver model, sampling on the falling edge
    logic p_stb = 1'b1, p_sclk = 1'b0, p_rdir = 1'b0, p_ready = 1'b1;
    int fall_c = 0, rise_c = 0, stbr_c = 0, cnt = 0, capn = 0, dir_rises = 0;
    bit first_rise = 0, srd = 0;
    logic [15:0] sh = '0;
    logic [11:0] rval = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_stb && !rf_stb) begin
                chk(cyc - acc_cyc == 1 + (cur_rd ? RL : WL) * DIV, "R4 lead", cyc - acc_cyc,
                    1 + (cur_rd ? RL : WL) * DIV);
                fall_c = cyc; first_rise = 1; cnt = 0; sh = '0; srd = 0; capn = 0; dir_rises = 0;
            end
            if (!p_sclk && rf_sclk) begin
                rise_c = cyc;
                if (first_rise)
                    chk(cyc - fall_c == ((cur_rd ? RG : WG) + SU) * DIV, "R4 gap", cyc - fall_c,
                        ((cur_rd ? RG : WG) + SU) * DIV);
                first_rise = 0;
                if (!rf_rdir) begin
                    sh = {sh[14:0], rf_sdo};
                    cnt++;
                end else begin
                    dir_rises++;
                    if (!srd) begin
                        srd = 1;
                        rval = sregs[sh[3:0]];
                    end else if (capn < 12) begin
                        rf_sdi = rval[11 - capn];
                        capn++;
                    end
                end
            end
            if (p_sclk && !rf_sclk) begin
                if (rf_rdir && dir_rises > 1) chk(cyc - rise_c == CH * DIV, "R7 capture high", cyc - rise_c, CH * DIV);
                else                          chk(cyc - rise_c == HI * DIV, "R3 clock high", cyc - rise_c, HI * DIV);
            end
            if (!p_stb && rf_stb) begin
                stbr_c = cyc;
                if (!srd) begin
                    chk(cnt == 16, "R3 edge count", cnt, 16);
                    chk(sh == exp_frame, "R3 frame", sh, exp_frame);
                    sregs[sh[3:0]] = sh[15:4];
                end else begin
                    chk(cnt == 5, "R6 addr bits", cnt, 5);
                    chk(sh[4:0] == {1'b0, exp_frame[3:0]}, "R6 addr", sh[4:0], {1'b0, exp_frame[3:0]});
                    chk(dir_rises == 13, "R7 dir edges", dir_rises, 13);
                end
            end
            if (p_rdir && !rf_rdir) chk(cyc - stbr_c == RT * DIV, "R9 tail", cyc - stbr_c, RT * DIV);
            if (!p_ready && req_ready)
                chk(cyc - stbr_c == ((cur_rd ? RT : WT) + TQ) * DIV, "R5 ready return", cyc - stbr_c,
                    ((cur_rd ? RT : WT) + TQ) * DIV);
            if (rd_done) begin
                if (exp_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
                else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R8 read data", rd_data, e);
                end
            end
        end
        p_stb = rf_stb; p_sclk = rf_sclk; p_rdir = rf_rdir; p_ready = req_ready;
    end

    // driver: pushes expected read values into the scoreboard queue
    task automatic xfer(input bit wr, input logic [3:0] a, input logic [11:0] d, input bit intrude);
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d;
        exp_frame = wr ? {d, a} : {12'h0, a};
        if (wr) exp_regs[a] = d;
        else    exp_q.push_back(exp_regs[a]);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        acc_cyc = cyc; cur_rd = !wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 ready drop", req_ready, 0);
        if (intrude) begin
            repeat (5) @(negedge clk);
            req_write = 1'b1; req_addr = a ^ 4'h1; req_wdata = ~d; req_valid = 1'b1;
            repeat (20) begin
                @(negedge clk);
                chk(!req_ready, "R2 busy", req_ready, 0);
            end
            req_valid = 1'b0;
        end
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(rf_stb == 1'b1,    "R1 stb",   rf_stb, 1);
        chk(rf_sclk == 1'b0,   "R1 sclk",  rf_sclk, 0);
        chk(rf_sdo_oe == 1'b0, "R1 oe",    rf_sdo_oe, 0);
        chk(rf_rdir == 1'b0,   "R1 rdir",  rf_rdir, 0);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(rd_done == 1'b0,   "R1 done",  rd_done, 0);

        xfer(1, 4'h3, 12'h5A1, 0);
        xfer(1, 4'hF, 12'hFFF, 0);
        xfer(1, 4'h8, 12'h801, 0);
        xfer(1, 4'h1, 12'h123, 0);
        xfer(0, 4'h3, 12'h0, 0);
        xfer(0, 4'hF, 12'h0, 0);
        xfer(0, 4'h8, 12'h0, 0);
        xfer(0, 4'h1, 12'h0, 0);
        xfer(0, 4'h5, 12'h0, 0);
        // R2: a request injected while busy must not reach register 9^1 = 8
        xfer(1, 4'h9, 12'h0F0, 1);
        xfer(0, 4'h9, 12'h0, 0);
        xfer(0, 4'h8, 12'h0, 1);
        xfer(0, 4'h9, 12'h0, 0);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R8 pending reads", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R2 watchdog expired", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule